// File: doc/BRIEF.md
# Genlocked VGA Sync Generator

This block produces the sync, blanking and coordinate signals for a 640x480 progressive display. It runs from the 27 MHz line-locked pixel clock of an NTSC video decoder and slaves its timing to that decoder. Every incoming NTSC line is cut into two output lines of half its length. This gives 525 output lines per NTSC field, so each field becomes one progressive frame at about 60 Hz.

A falling edge on the decoder's active-low horizontal sync restarts the output line. Between decoder syncs, the internal counter wraps at its own nominal length, so the second half-line and any stretch with missing decoder syncs are timed locally. Any change of level on the decoder's field signal restarts the frame at line 0. The new field level is also published as the current field. Downstream pixel logic uses the active flag and the window coordinates to place pixels.

Top module: `gvs_genlock_sync`

## Requirements
- R1: While reset is high, and on the first cycle after reset, the position state is line 0, clock 0. The outputs are hsync low, vsync low, active low, both coordinates 0, and field indication 0.
- R2: When the decoder HS input is high in one clock and low in the next, the output line restarts. On the following cycle the line position is 0, whatever the position was before.
- R3: An output line lasts H_TOT = NTSC_LINE_CLKS/2 clocks. With no decoder HS edge, the line position wraps from H_TOT-1 to 0, so the block free-runs at nominal timing.
- R4: The output hsync is low for the first H_SYNC clocks of each line and high for the rest of the line.
- R5: The line counter advances once at each line start and wraps from V_TOT-1 to 0. The output vsync is low during lines 0 to V_SYNC-1 and high otherwise.
- R6: Any transition of the decoder field input, rising or falling, sets the line counter to 0 on the next cycle. This takes priority over a line advance.
- R7: The field indication takes the new level of the field input at each field transition: 0 marks field 1 (even lines) and 1 marks field 2 (odd lines).
- R8: Active is high only when the line position lies in [H_SYNC+H_BP, H_SYNC+H_BP+H_ACT) and the line counter lies in [V_SYNC+V_BP, V_SYNC+V_BP+V_ACT).
- R9: While active, pix_x and pix_y give the offset of the position inside that window. Both are 0 while active is low.
- R10: A decoder HS edge that falls in the same cycle as the natural wrap starts only one line, so the line counter advances by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder pixel clock, 27 MHz |
| rst | input | 1 | Synchronous reset, active high |
| dec_hs_n | input | 1 | Decoder horizontal sync, active low |
| dec_field | input | 1 | Decoder field level, 0 = field 1, 1 = field 2 |
| vga_hsync_n | output | 1 | Output horizontal sync, active low |
| vga_vsync_n | output | 1 | Output vertical sync, active low |
| vid_active | output | 1 | High inside the 640x480 visible window |
| pix_x | output | $clog2(H_ACT) | Column inside the visible window |
| pix_y | output | $clog2(V_ACT) | Row inside the visible window |
| field_odd | output | 1 | Current field, 1 = field 2 (odd lines) |

## Verification
A line position that drifts or fails to restart shows up within one line as a shifted hsync pulse. It also shows up as a pix_x offset at the edge of the window. A line counter that skips, double-counts, or misses a field restart moves the vsync pulse and changes pix_y. Its effect is visible on the first active line after the fault, or on the next cycle when the field input changes. The bench compares sampled outputs against window positions computed from the timing parameters. It also drives off-phase syncs, silent sync periods and field transitions in both directions.

// File: rtl/gvs_pkg.sv
package gvs_pkg;

    // Nominal timing at a 27 MHz line-locked clock
    localparam int unsigned DEF_NTSC_LINE = 1716;
    localparam int unsigned DEF_H_SYNC    = 102;
    localparam int unsigned DEF_H_BP      = 51;
    localparam int unsigned DEF_H_ACT     = 640;
    localparam int unsigned DEF_V_SYNC    = 2;
    localparam int unsigned DEF_V_BP      = 33;
    localparam int unsigned DEF_V_ACT     = 480;
    localparam int unsigned DEF_V_TOT     = 525;

    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic active;
    } gvs_flags_t;

    function automatic int unsigned gvs_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/gvs_edge_detect.sv
module gvs_edge_detect #(
    parameter bit IDLE_LVL = 1'b1,
    parameter bit ANY_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_LVL;
        else     prev_q <= din;
    end

    generate
        if (ANY_EDGE) begin : g_any
            assign pulse = prev_q ^ din;
        end else begin : g_fall
            assign pulse = prev_q & ~din;
        end
    endgenerate

endmodule

// File: rtl/gvs_hcount.sv
module gvs_hcount #(
    parameter int unsigned H_TOT = 858,
    localparam int unsigned HW   = gvs_pkg::gvs_bits(H_TOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [HW-1:0] hpos,
    output logic          line_start
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);

    assign line_start = restart || (hpos == H_LAST);

    always_ff @(posedge clk) begin
        if (rst)             hpos <= '0;
        else if (line_start) hpos <= '0;
        else                 hpos <= hpos + 1'b1;
    end

    // R2: a decoder sync edge restarts the line on the next cycle
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (hpos == '0));

    // R3: without a restart the position steps by one until the wrap
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!restart && hpos != H_LAST) |=> (hpos == HW'($past(hpos) + 1'b1)));

    // R3: the position never passes the last clock of a line
    assert_bound_R3: assert property (@(posedge clk) disable iff (rst)
        hpos <= H_LAST);

endmodule

// File: rtl/gvs_vcount.sv
module gvs_vcount #(
    parameter int unsigned V_TOT = 525,
    localparam int unsigned VW   = gvs_pkg::gvs_bits(V_TOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          clear,
    output logic [VW-1:0] vline
);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

    always_ff @(posedge clk) begin
        if (rst)                  vline <= '0;
        else if (clear)           vline <= '0;
        else if (line_start)      vline <= (vline == V_LAST) ? '0 : vline + 1'b1;
    end

    // R6: a field transition forces line 0 regardless of a line advance
    assert_field_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (vline == '0));

    // R5: the line counter stays inside the frame
    assert_vrange_R5: assert property (@(posedge clk) disable iff (rst)
        vline <= V_LAST);

    // R10: a line start advances the counter by exactly one
    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        (line_start && !clear && vline != V_LAST) |=> (vline == VW'($past(vline) + 1'b1)));

endmodule

// File: rtl/gvs_genlock_sync.sv
module gvs_genlock_sync #(
    parameter int unsigned NTSC_LINE_CLKS = gvs_pkg::DEF_NTSC_LINE,
    parameter int unsigned H_SYNC         = gvs_pkg::DEF_H_SYNC,
    parameter int unsigned H_BP           = gvs_pkg::DEF_H_BP,
    parameter int unsigned H_ACT          = gvs_pkg::DEF_H_ACT,
    parameter int unsigned V_SYNC         = gvs_pkg::DEF_V_SYNC,
    parameter int unsigned V_BP           = gvs_pkg::DEF_V_BP,
    parameter int unsigned V_ACT          = gvs_pkg::DEF_V_ACT,
    parameter int unsigned V_TOT          = gvs_pkg::DEF_V_TOT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     dec_hs_n,
    input  logic                     dec_field,
    output logic                     vga_hsync_n,
    output logic                     vga_vsync_n,
    output logic                     vid_active,
    output logic [$clog2(H_ACT)-1:0] pix_x,
    output logic [$clog2(V_ACT)-1:0] pix_y,
    output logic                     field_odd
);
    import gvs_pkg::*;

    localparam int unsigned H_TOT = NTSC_LINE_CLKS / 2;
    localparam int unsigned HW    = gvs_bits(H_TOT);
    localparam int unsigned VW    = gvs_bits(V_TOT);
    localparam int unsigned XW    = $clog2(H_ACT);
    localparam int unsigned YW    = $clog2(V_ACT);

    localparam logic [HW-1:0] H_SYNC_END = HW'(H_SYNC);
    localparam logic [HW-1:0] H_WIN_LO   = HW'(H_SYNC + H_BP);
    localparam logic [HW-1:0] H_WIN_HI   = HW'(H_SYNC + H_BP + H_ACT);
    localparam logic [VW-1:0] V_SYNC_END = VW'(V_SYNC);
    localparam logic [VW-1:0] V_WIN_LO   = VW'(V_SYNC + V_BP);
    localparam logic [VW-1:0] V_WIN_HI   = VW'(V_SYNC + V_BP + V_ACT);

    logic          hs_fall;
    logic          fld_edge;
    logic          line_start;
    logic [HW-1:0] hpos;
    logic [VW-1:0] vline;
    logic [HW-1:0] x_off;
    logic [VW-1:0] y_off;
    gvs_flags_t    flags;

    gvs_edge_detect #(.IDLE_LVL(1'b1), .ANY_EDGE(1'b0)) u_hs_edge (
        .clk(clk), .rst(rst), .din(dec_hs_n), .pulse(hs_fall)
    );

    gvs_edge_detect #(.IDLE_LVL(1'b0), .ANY_EDGE(1'b1)) u_fld_edge (
        .clk(clk), .rst(rst), .din(dec_field), .pulse(fld_edge)
    );

    gvs_hcount #(.H_TOT(H_TOT)) u_hcount (
        .clk(clk), .rst(rst), .restart(hs_fall),
        .hpos(hpos), .line_start(line_start)
    );

    gvs_vcount #(.V_TOT(V_TOT)) u_vcount (
        .clk(clk), .rst(rst), .line_start(line_start),
        .clear(fld_edge), .vline(vline)
    );

    always_ff @(posedge clk) begin
        if (rst)           field_odd <= 1'b0;
        else if (fld_edge) field_odd <= dec_field;
    end

    always_comb begin
        flags.hsync_n = (hpos >= H_SYNC_END);
        flags.vsync_n = (vline >= V_SYNC_END);
        flags.active  = (hpos >= H_WIN_LO) && (hpos < H_WIN_HI) &&
                        (vline >= V_WIN_LO) && (vline < V_WIN_HI);
        x_off = hpos - H_WIN_LO;
        y_off = vline - V_WIN_LO;
    end

    assign vga_hsync_n = flags.hsync_n;
    assign vga_vsync_n = flags.vsync_n;
    assign vid_active  = flags.active;
    assign pix_x       = flags.active ? x_off[XW-1:0] : '0;
    assign pix_y       = flags.active ? y_off[YW-1:0] : '0;

    // R7: the field indication follows the field level after each transition
    assert_field_level_R7: assert property (@(posedge clk) disable iff (rst)
        fld_edge |=> (field_odd == $past(dec_field)));

    // R8: the visible window never overlaps a sync pulse
    assert_active_clear_of_sync_R8: assert property (@(posedge clk) disable iff (rst)
        vid_active |-> (vga_hsync_n && vga_vsync_n));

    // R9: coordinates rest at zero outside the window
    assert_coords_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !vid_active |-> (pix_x == '0 && pix_y == '0));

    // R4: hsync drops only at the start of a line
    assert_hsync_start_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(vga_hsync_n) |-> (hpos == '0));

endmodule

// File: tb/gvs_genlock_sync_tb.sv
module gvs_genlock_sync_tb_top;

    localparam int NL   = 40;   // NTSC line, gives a 20-clock output line
    localparam int HSW  = 3;
    localparam int HBP  = 2;
    localparam int HACT = 12;
    localparam int VSW  = 2;
    localparam int VBP  = 3;
    localparam int VACT = 8;
    localparam int VTOT = 16;

    typedef struct packed {
        int idx;
        bit hs;
        bit vs;
        bit act;
        int x;
        int y;
    } vec_t;

    // Output line 20 clocks: hsync low h<3, window h in [5,17), v in [5,13), vsync low v<2
    localparam int VEC_N = 13;
    localparam vec_t VECS [VEC_N] = '{
        '{0,   1'b0, 1'b0, 1'b0, 0,  0},
        '{2,   1'b0, 1'b0, 1'b0, 0,  0},
        '{3,   1'b1, 1'b0, 1'b0, 0,  0},
        '{25,  1'b1, 1'b0, 1'b0, 0,  0},
        '{45,  1'b1, 1'b1, 1'b0, 0,  0},
        '{104, 1'b1, 1'b1, 1'b0, 0,  0},
        '{105, 1'b1, 1'b1, 1'b1, 0,  0},
        '{116, 1'b1, 1'b1, 1'b1, 11, 0},
        '{117, 1'b1, 1'b1, 1'b0, 0,  0},
        '{256, 1'b1, 1'b1, 1'b1, 11, 7},
        '{259, 1'b1, 1'b1, 1'b0, 0,  0},
        '{265, 1'b1, 1'b1, 1'b0, 0,  0},
        '{330, 1'b1, 1'b0, 1'b0, 0,  0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_hs_n = 1'b1;
    logic dec_field = 1'b0;
    logic vga_hsync_n, vga_vsync_n, vid_active, field_odd;
    logic [$clog2(HACT)-1:0] pix_x;
    logic [$clog2(VACT)-1:0] pix_y;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gvs_genlock_sync #(
        .NTSC_LINE_CLKS(NL), .H_SYNC(HSW), .H_BP(HBP), .H_ACT(HACT),
        .V_SYNC(VSW), .V_BP(VBP), .V_ACT(VACT), .V_TOT(VTOT)
    ) dut_i (
        .clk(clk), .rst(rst), .dec_hs_n(dec_hs_n), .dec_field(dec_field),
        .vga_hsync_n(vga_hsync_n), .vga_vsync_n(vga_vsync_n),
        .vid_active(vid_active), .pix_x(pix_x), .pix_y(pix_y),
        .field_odd(field_odd)
    );

    task automatic chk(input bit ok, input string req, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, detail);
        end
    endtask

    task automatic chk_reset_state(input string req);
        chk(vga_hsync_n == 1'b0 && vga_vsync_n == 1'b0 && vid_active == 1'b0 &&
            pix_x == '0 && pix_y == '0 && field_odd == 1'b0, req,
            $sformatf("actual hs=%0b vs=%0b act=%0b x=%0d y=%0d f=%0b expected 0 0 0 0 0 0",
                      vga_hsync_n, vga_vsync_n, vid_active, pix_x, pix_y, field_odd));
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int vp;
        int lows;
        int falls;
        logic prev;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk_reset_state("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(vga_hsync_n == 1'b0 && vga_vsync_n == 1'b0 && vid_active == 1'b0, "R1",
            $sformatf("first cycle after reset hs=%0b vs=%0b act=%0b expected 0 0 0",
                      vga_hsync_n, vga_vsync_n, vid_active));

        // Frame start: HS edge and field rising together, then a locked NTSC line stream
        dec_hs_n  = 1'b0;
        dec_field = 1'b1;
        vp = 0;
        for (int c = 0; c < 340; c++) begin
            @(negedge clk);
            if (vp < VEC_N && VECS[vp].idx == c) begin
                // R4 R5 R8 R9 R10 window and sync decode
                chk(vga_hsync_n == VECS[vp].hs && vga_vsync_n == VECS[vp].vs &&
                    vid_active == VECS[vp].act && int'(pix_x) == VECS[vp].x &&
                    int'(pix_y) == VECS[vp].y, "R4/R5/R8/R9/R10",
                    $sformatf("idx %0d actual hs=%0b vs=%0b act=%0b x=%0d y=%0d expected %0b %0b %0b %0d %0d",
                              c, vga_hsync_n, vga_vsync_n, vid_active, pix_x, pix_y,
                              VECS[vp].hs, VECS[vp].vs, VECS[vp].act, VECS[vp].x, VECS[vp].y));
                vp++;
            end
            if (c == 0)
                chk(field_odd == 1'b1, "R7",
                    $sformatf("rising field actual=%0b expected=1", field_odd));
            dec_hs_n = (c % 40 == 39) ? 1'b0 : 1'b1;
        end

        // R3: decoder HS silent, free-running at 20 clocks per line
        dec_hs_n = 1'b1;
        lows = 0;
        falls = 0;
        prev = vga_hsync_n;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!vga_hsync_n) lows++;
            if (prev && !vga_hsync_n) falls++;
            prev = vga_hsync_n;
        end
        chk(lows == 15, "R3", $sformatf("free-run low clocks actual=%0d expected=15", lows));
        chk(falls == 5, "R3", $sformatf("free-run sync pulses actual=%0d expected=5", falls));

        // R2: off-phase HS edge restarts the line
        for (int k = 0; k < 50 && vga_hsync_n; k++) @(negedge clk);
        for (int k = 0; k < 50 && !vga_hsync_n; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(vga_hsync_n == 1'b1, "R2", $sformatf("before relock hs actual=%0b expected=1", vga_hsync_n));
        dec_hs_n = 1'b0;
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            if (k == 1) dec_hs_n = 1'b1;
            if (k >= 1 && k <= 3)
                chk(vga_hsync_n == 1'b0, "R2",
                    $sformatf("relock step %0d hs actual=%0b expected=0", k, vga_hsync_n));
            if (k == 4)
                chk(vga_hsync_n == 1'b1, "R4",
                    $sformatf("pulse end hs actual=%0b expected=1", vga_hsync_n));
            if (k == 20)
                chk(vga_hsync_n == 1'b1, "R3",
                    $sformatf("line end hs actual=%0b expected=1", vga_hsync_n));
            if (k == 21)
                chk(vga_hsync_n == 1'b0, "R3",
                    $sformatf("next line hs actual=%0b expected=0", vga_hsync_n));
        end

        // R6: falling field edge mid-frame restarts the frame
        for (int k = 0; k < 800 && !vga_vsync_n; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(vga_vsync_n == 1'b1, "R6", $sformatf("before field edge vs actual=%0b expected=1", vga_vsync_n));
        dec_field = 1'b0;
        for (int k = 1; k <= 41; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk(vga_vsync_n == 1'b0, "R6",
                    $sformatf("after field edge vs actual=%0b expected=0", vga_vsync_n));
                chk(field_odd == 1'b0, "R7",
                    $sformatf("falling field actual=%0b expected=0", field_odd));
            end
            if (k == 20)
                chk(vga_vsync_n == 1'b0, "R5",
                    $sformatf("vsync still in sync lines actual=%0b expected=0", vga_vsync_n));
            if (k == 41)
                chk(vga_vsync_n == 1'b1, "R5",
                    $sformatf("vsync after two lines actual=%0b expected=1", vga_vsync_n));
        end

        // R1: reset in mid-frame returns to the reset state
        dec_field = 1'b1;
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        dec_field = 1'b0;
        @(negedge clk);
        chk_reset_state("R1 mid-run");
        rst = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule